// File: doc/BRIEF.md
# Multichannel Sampling Converter Serial Output Model

This block is a synthesizable stand-in for the serial output side of a multichannel sampling converter. Use it as a stimulus partner when you verify a capture controller. The block runs on the serial clock and watches a convert strobe. On the serial clock edge where it first sees the strobe high, it latches up to six parallel sample words and a channel-count setting. It then drives a serial data line together with an output enable. A low output enable stands for the high-impedance state.

After the strobe, a short lead-in of serial clock edges passes. Then one 16-bit slot is sent per selected channel, in channel order. Each slot holds the 12-bit sample with its most significant bit first. Two filler bits follow, driven low, and then two cycles in which the line is released. When the last selected slot ends, the line stays released until the next strobe. A new strobe in the middle of a frame abandons that frame and starts over.

Top module: `adc_serial_out_model`

## Requirements
- R1: While reset is asserted, and after it is released, `sdo_oe_o` is 0.
- R2: With no rising edge on `conv_i`, `sdo_oe_o` stays 0, whatever happens on `samples_i` or `chan_sel_i`.
- R3: A rise of `conv_i` counts at the first `sck_i` rising edge that samples it high after sampling it low; call that edge 0. The line stays released after edges 0, 1 and 2. The first data bit appears after edge 3.
- R4: Counting from edge 3, the bit with index b (starting at 0) belongs to slot b/16 at position b%16. Slot k carries channel k, where channel k is `samples_i[12k+11:12k]`. Positions 0 to 11 carry the channel's bits 11 down to 0, and `sdo_oe_o` is 1 for them.
- R5: Positions 12 and 13 of each slot have `sdo_oe_o` = 1 and `sdo_o` = 0.
- R6: Positions 14 and 15 of each slot have `sdo_oe_o` = 0.
- R7: A frame with n selected channels is 16·n bits long. From bit index 16·n onward, `sdo_oe_o` stays 0 until the next strobe.
- R8: A `chan_sel_i` value of 1 to 6 selects that many channels. The values 0 and 7 select six channels.
- R9: The sample words and the channel count come from their values at edge 0. Later changes to these inputs do not affect the frame.
- R10: A rise of `conv_i` during a frame restarts the sequence from R3, using newly latched samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Serial clock; all state advances on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert strobe, sampled on `sck_i` |
| chan_sel_i | input | 3 | Number of channels per frame |
| samples_i | input | 72 | Six 12-bit sample words, channel 0 in the low bits |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Drive enable; 0 means the line is released |

## Verification
The bound checker checks, on every cycle, the local slot rules that tie the sequencer phase and bit position to the pins. These rules are:
- the line is released while the block is idle, during the lead-in and during the gap positions;
- the line is driven and low at the filler positions;
- the line is driven for every data position;
- a strobe rise always returns the sequencer to the lead-in.

Only the bench scenarios can show four further things: the actual data bit values and their channel order, the frame length for each channel-count setting, the latching of the samples at edge 0, and the exact result of a restart or reset in the middle of a frame.

// File: rtl/som_pkg.sv
package som_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LEAD = 2'd1,
      PH_DATA = 2'd2
   } seq_phase_t;

   // Channel-count decode: 1..max selects that many, anything else selects all.
   function automatic int unsigned chan_count(input int unsigned sel,
                                              input int unsigned max_ch);
      if (sel == 0 || sel > max_ch) return max_ch;
      return sel;
   endfunction

endpackage

// File: rtl/som_strobe_edge.sv
module som_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic start_o
);
   logic strobe_q;

   // Reset to 1 so that a strobe already high when reset is released does not start a frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b1;
      else        strobe_q <= strobe_i;
   end

   assign start_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/som_sample_bank.sv
module som_sample_bank
   import som_pkg::*;
#(
   parameter int NUM_CH   = 6,
   parameter int SAMPLE_W = 12,
   parameter int SEL_W    = 3,
   localparam int NCH_W   = $clog2(NUM_CH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
   input  logic [SEL_W-1:0]           sel_i,
   output logic [SAMPLE_W-1:0]        words_o [NUM_CH],
   output logic [NCH_W-1:0]           nch_o
);
   // One holding register per channel.
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [SAMPLE_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      word_q <= '0;
         else if (load_i) word_q <= samples_i[ch*SAMPLE_W +: SAMPLE_W];
      end
      assign words_o[ch] = word_q;
   end

   logic [NCH_W-1:0] nch_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      nch_q <= NCH_W'(NUM_CH);
      else if (load_i) nch_q <= NCH_W'(chan_count(int'(sel_i), NUM_CH));
   end
   assign nch_o = nch_q;
endmodule

// File: rtl/som_frame_seq.sv
module som_frame_seq
   import som_pkg::*;
#(
   parameter int NUM_CH     = 6,
   parameter int SLOT_LEN   = 16,
   parameter int LEAD_EDGES = 3,
   localparam int NCH_W     = $clog2(NUM_CH + 1),
   localparam int SLOT_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int POS_W     = $clog2(SLOT_LEN),
   localparam int LEAD_W    = (LEAD_EDGES > 1) ? $clog2(LEAD_EDGES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NCH_W-1:0]  nch_i,
   output seq_phase_t        phase_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [POS_W-1:0]  pos_o
);
   localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(SLOT_LEN - 1);
   localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_EDGES - 1);

   seq_phase_t        phase_q;
   logic [SLOT_W-1:0] slot_q;
   logic [POS_W-1:0]  pos_q;
   logic [LEAD_W-1:0] lead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         slot_q  <= '0;
         pos_q   <= '0;
         lead_q  <= '0;
      end else if (start_i) begin
         // A strobe rise always wins, including in the middle of a frame.
         phase_q <= PH_LEAD;
         lead_q  <= '0;
         slot_q  <= '0;
         pos_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_LEAD: begin
               if (lead_q == LEAD_LAST) begin
                  phase_q <= PH_DATA;
                  slot_q  <= '0;
                  pos_q   <= '0;
               end else begin
                  lead_q <= lead_q + 1'b1;
               end
            end
            PH_DATA: begin
               if (pos_q == POS_LAST) begin
                  pos_q <= '0;
                  if (int'(slot_q) >= int'(nch_i) - 1) phase_q <= PH_IDLE;
                  else                                 slot_q  <= slot_q + 1'b1;
               end else begin
                  pos_q <= pos_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign slot_o  = slot_q;
   assign pos_o   = pos_q;
endmodule

// File: rtl/som_serializer.sv
module som_serializer
   import som_pkg::*;
#(
   parameter int   NUM_CH    = 6,
   parameter int   SAMPLE_W  = 12,
   parameter int   PAD_W     = 2,
   parameter int   SLOT_LEN  = 16,
   parameter bit   PAD_LEVEL = 1'b0,
   parameter bit   LSB_FIRST = 1'b0,
   localparam int  SLOT_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int  POS_W     = $clog2(SLOT_LEN)
) (
   input  seq_phase_t          phase_i,
   input  logic [SLOT_W-1:0]   slot_i,
   input  logic [POS_W-1:0]    pos_i,
   input  logic [SAMPLE_W-1:0] words_i [NUM_CH],
   output logic                sdo_o,
   output logic                oe_o
);
   logic [SAMPLE_W-1:0] word;
   logic                data_bit;
   int                  bit_sel;

   always_comb begin
      word = '0;
      for (int ch = 0; ch < NUM_CH; ch++)
         if (int'(slot_i) == ch) word = words_i[ch];
   end

   // The order variant is chosen at elaboration.
   if (LSB_FIRST) begin : g_lsb
      assign bit_sel = int'(pos_i);
   end else begin : g_msb
      assign bit_sel = SAMPLE_W - 1 - int'(pos_i);
   end

   always_comb begin
      data_bit = 1'b0;
      for (int i = 0; i < SAMPLE_W; i++)
         if (bit_sel == i) data_bit = word[i];
   end

   always_comb begin
      sdo_o = 1'b0;
      oe_o  = 1'b0;
      if (phase_i == PH_DATA) begin
         if (int'(pos_i) < SAMPLE_W) begin
            sdo_o = data_bit;
            oe_o  = 1'b1;
         end else if (int'(pos_i) < SAMPLE_W + PAD_W) begin
            sdo_o = PAD_LEVEL;
            oe_o  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_serial_out_model.sv
module adc_serial_out_model
   import som_pkg::*;
#(
   parameter int NUM_CH     = 6,
   parameter int SAMPLE_W   = 12,
   parameter int PAD_W      = 2,
   parameter int GAP_W      = 2,
   parameter int LEAD_EDGES = 3,
   parameter int SEL_W      = 3,
   localparam int SLOT_LEN  = SAMPLE_W + PAD_W + GAP_W,
   localparam int NCH_W     = $clog2(NUM_CH + 1),
   localparam int SLOT_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int POS_W     = $clog2(SLOT_LEN)
) (
   input  logic                       sck_i,
   input  logic                       rst_ni,
   input  logic                       conv_i,
   input  logic [SEL_W-1:0]           chan_sel_i,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
   output logic                       sdo_o,
   output logic                       sdo_oe_o
);
   // Parameter checks at elaboration.
   if (NUM_CH < 1)                  begin : g_bad_ch   $error("NUM_CH must be at least 1"); end
   if (SAMPLE_W < 1)                begin : g_bad_w    $error("SAMPLE_W must be at least 1"); end
   if (LEAD_EDGES < 1)              begin : g_bad_lead $error("LEAD_EDGES must be at least 1"); end
   if ((1 << SEL_W) <= NUM_CH)      begin : g_bad_sel  $error("SEL_W too narrow for NUM_CH"); end
   if ((1 << POS_W) != SLOT_LEN)    begin : g_bad_slot $error("slot length must be a power of two"); end

   logic                start_w;
   logic [SAMPLE_W-1:0] words_w [NUM_CH];
   logic [NCH_W-1:0]    nch_w;
   seq_phase_t          phase_w;
   logic [SLOT_W-1:0]   slot_w;
   logic [POS_W-1:0]    pos_w;

   som_strobe_edge u_edge (
      .clk      (sck_i),
      .rst_n    (rst_ni),
      .strobe_i (conv_i),
      .start_o  (start_w)
   );

   som_sample_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W)) u_bank (
      .clk       (sck_i),
      .rst_n     (rst_ni),
      .load_i    (start_w),
      .samples_i (samples_i),
      .sel_i     (chan_sel_i),
      .words_o   (words_w),
      .nch_o     (nch_w)
   );

   som_frame_seq #(.NUM_CH(NUM_CH), .SLOT_LEN(SLOT_LEN), .LEAD_EDGES(LEAD_EDGES)) u_seq (
      .clk     (sck_i),
      .rst_n   (rst_ni),
      .start_i (start_w),
      .nch_i   (nch_w),
      .phase_o (phase_w),
      .slot_o  (slot_w),
      .pos_o   (pos_w)
   );

   som_serializer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W),
                    .SLOT_LEN(SLOT_LEN), .PAD_LEVEL(1'b0), .LSB_FIRST(1'b0)) u_ser (
      .phase_i (phase_w),
      .slot_i  (slot_w),
      .pos_i   (pos_w),
      .words_i (words_w),
      .sdo_o   (sdo_o),
      .oe_o    (sdo_oe_o)
   );
endmodule

// File: rtl/som_checker.sv
module som_checker
   import som_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int PAD_W    = 2,
   parameter int POS_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input seq_phase_t       phase,
   input logic [POS_W-1:0] pos,
   input logic             sdo,
   input logic             oe
);
   // R1: the line is released while reset is held
   always @(posedge clk) begin
      if (!rst_n) assert_reset_hiz_R1: assert (!oe);
   end

   assert_idle_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !oe);

   assert_lead_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LEAD) |-> !oe);

   assert_data_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && int'(pos) < SAMPLE_W) |-> oe);

   assert_pad_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && int'(pos) >= SAMPLE_W && int'(pos) < SAMPLE_W + PAD_W)
      |-> (oe && !sdo));

   assert_gap_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && int'(pos) >= SAMPLE_W + PAD_W) |-> !oe);

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (phase == PH_LEAD && !oe));
endmodule

bind adc_serial_out_model som_checker #(
   .SAMPLE_W (SAMPLE_W),
   .PAD_W    (PAD_W),
   .POS_W    (POS_W)
) u_som_chk (
   .clk   (sck_i),
   .rst_n (rst_ni),
   .start (start_w),
   .phase (phase_w),
   .pos   (pos_w),
   .sdo   (sdo_o),
   .oe    (sdo_oe_o)
);

// File: tb/tb_adc_serial_out_model.sv
module tb_adc_serial_out_model;
   localparam int NCH = 6;
   localparam int W   = 12;

   logic          sck = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv = 1'b0;
   logic [2:0]    sel = 3'd6;
   logic [NCH*W-1:0] smp = '0;
   logic          sdo, oe;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 sck = ~sck;   // 125 MHz

   adc_serial_out_model dut (
      .sck_i      (sck),
      .rst_ni     (rst_n),
      .conv_i     (conv),
      .chan_sel_i (sel),
      .samples_i  (smp),
      .sdo_o      (sdo),
      .sdo_oe_o   (oe)
   );

   function automatic int exp_count(input logic [2:0] s);
      return (s == 3'd0 || s > 3'd6) ? 6 : int'(s);   // R8
   endfunction

   // Expected {oe, data} for bit index b of a frame with n channels
   function automatic logic [1:0] exp_out(input int b, input int n, input logic [NCH*W-1:0] s);
      int slot, p;
      if (b < 0 || b >= 16 * n) return 2'b00;
      slot = b / 16;
      p = b % 16;
      if (p < W)  return {1'b1, s[slot*W + (W - 1 - p)]};
      if (p < 14) return 2'b10;
      return 2'b00;
   endfunction

   function automatic string req_of(input int b, input int n);
      int p;
      if (b < 0) return "R3";
      if (b >= 16 * n) return "R7";
      p = b % 16;
      if (p < W) return "R4";
      if (p < 14) return "R5";
      return "R6";
   endfunction

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act[1] !== exp[1] || (exp[1] && act[0] !== exp[0])) begin
         errors++;
         $display("FAIL %s: actual oe/sdo=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic start_conv(input logic [NCH*W-1:0] s, input logic [2:0] c);
      smp  = s;
      sel  = c;
      conv = 1'b1;
   endtask

   // Called right after start_conv, at a falling edge. Watches ncyc edges after edge 0.
   task automatic observe(input logic [NCH*W-1:0] s, input logic [2:0] c, input int ncyc,
                          input string tag);
      int n;
      n = exp_count(c);
      @(posedge sck); @(negedge sck);
      chk({tag, "/R3 edge0"}, {oe, sdo}, 2'b00);
      conv = 1'b0;
      smp  = {$urandom, $urandom, $urandom};   // R9: must not reach the frame
      sel  = 3'($urandom);                     // R9 / R8
      for (int k = 1; k <= ncyc; k++) begin
         @(posedge sck); @(negedge sck);
         chk({tag, "/", req_of(k - 3, n), (c == 0 || c == 7) ? "/R8" : "", "/R9"},
             {oe, sdo}, exp_out(k - 3, n, s));
      end
   endtask

   task automatic full_frame(input logic [NCH*W-1:0] s, input logic [2:0] c, input string tag);
      start_conv(s, c);
      observe(s, c, 3 + 16 * exp_count(c) + 4, tag);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [NCH*W-1:0] s1, s2;
      void'($urandom(32'd20240611));
      // R1: released during reset
      repeat (3) @(negedge sck);
      chk("R1 in reset", {oe, sdo}, 2'b00);
      rst_n = 1'b1;
      @(negedge sck);
      chk("R1 after reset", {oe, sdo}, 2'b00);

      // R2: no strobe, busy inputs
      for (int i = 0; i < 20; i++) begin
         smp = {$urandom, $urandom, $urandom};
         sel = 3'($urandom);
         @(negedge sck);
         chk("R2 idle", {oe, sdo}, 2'b00);
      end

      // Directed corner frames
      full_frame({NCH*W{1'b1}}, 3'd6, "ones");
      full_frame({6{12'hA5C}}, 3'd1, "single");
      full_frame(72'h123_456_789_ABC_DEF_0F1, 3'd0, "sel0");
      full_frame(72'hFED_CBA_987_654_321_800, 3'd7, "sel7");
      full_frame(72'h001_002_004_008_010_020, 3'd3, "three");

      // R10: restart mid-frame (in the data of slot 1)
      s1 = {$urandom, $urandom, $urandom};
      s2 = {$urandom, $urandom, $urandom};
      start_conv(s1, 3'd6);
      observe(s1, 3'd6, 22, "R10 first");
      full_frame(s2, 3'd2, "R10 restart");

      // R10: restart during lead-in
      start_conv(s1, 3'd4);
      observe(s1, 3'd4, 1, "R10 lead");
      full_frame(s2, 3'd4, "R10 relead");

      // R1: reset in mid-frame
      start_conv(s1, 3'd6);
      observe(s1, 3'd6, 10, "R1 pre");
      rst_n = 1'b0;
      @(negedge sck);
      chk("R1 mid-frame reset", {oe, sdo}, 2'b00);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge sck);
         chk("R1/R2 after reset", {oe, sdo}, 2'b00);
      end

      // Random frames
      for (int f = 0; f < 30; f++)
         full_frame({$urandom, $urandom, $urandom}, 3'($urandom), "rand");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule